// File: doc/BRIEF.md
# Translation Permission Check Unit

This block decides whether a memory access is allowed. It reads one decoded leaf translation entry and works out a full set of read, write and execute rights for both the user context and the kernel context. It then checks the requested access against the context that applies. The entry supplies a two-bit permission field and two execute-never bits, one for user level and one for privileged level. The access supplies an exception level, a read, write or fetch type, and a flag for explicitly unprivileged loads and stores.

A user-guard flag stops privileged data accesses to pages that user level can reach. The `strict_i` input selects what "reachable from user level" means. When low, only user-readable pages count. When high, a page also counts if it is user-executable. The strict setting closes the hole where an execute-only user page escapes the guard. Each verdict is registered and appears one cycle after its strobe, as an allow bit and a two-bit fault code.

Top module: `perm_check_unit`

## Requirements
- R1: Field encodings are as follows. For `acc_i`: 00 is read, 01 is write, 10 is fetch, and 11 is decoded as read. For the permission field `ap_i`: 00 gives kernel RW and user none, 01 gives kernel RW and user RW, 10 gives kernel RO and user none, 11 gives kernel RO and user RO. The kernel context may always read and may write only when `ap_i[1]` is 0.
- R2: The user context may read when `ap_i[0]` is 1 and may write only when `ap_i` is 01. It may execute exactly when `uxn_i` is 0. As a result, `ap_i`=10 with `uxn_i`=0 gives a user execute-only page that the kernel can only read.
- R3: A fetch in the kernel context faults with code 10 when `pxn_i` is 1 or when `ap_i` is 01 (the page is user-writable).
- R4: A fetch at level 0 faults with code 10 exactly when `uxn_i` is 1.
- R5: Exception levels are encoded as 0 user, 1 kernel, 2 hypervisor, 3 monitor. At level 1, when `guard_i` is 1, a data access to a user-reachable page faults with code 11. When `guard_i` is 0, no code-11 fault occurs.
- R6: At level 2 the guard check applies only when `hostx_i` is 1. At levels 0 and 3 it never applies.
- R7: When `strict_i` is 0, only a user-readable page counts as user-reachable, so an execute-only user page does not raise code 11.
- R8: When `strict_i` is 1, a page counts as user-reachable if it is user-readable or if `uxn_i` is 0.
- R9: Instruction fetches never raise code 11.
- R10: Data accesses with `unpriv_i` set are checked against the user rights and skip the guard check. On fetches, `unpriv_i` is ignored.
- R11: Fault codes are 00 none, 01 read/write, 10 execute, 11 guard. When a guard fault and a read/write fault both apply, the result is 11.
- R12: `valid_o`, `allow_o` and `fault_o` reflect the access strobed by `valid_i` one cycle earlier, and `allow_o` is 1 exactly when `fault_o` is 00. While `valid_i` is low, `valid_o` drops and `allow_o` and `fault_o` keep their values.
- R13: After reset, `valid_o` is 0, `allow_o` is 0 and `fault_o` is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Access strobe |
| ap_i | input | 2 | Entry permission field |
| uxn_i | input | 1 | User execute-never |
| pxn_i | input | 1 | Privileged execute-never |
| el_i | input | 2 | Current exception level |
| guard_i | input | 1 | User-guard state flag |
| hostx_i | input | 1 | Hypervisor host-extension control |
| acc_i | input | 2 | Access type |
| unpriv_i | input | 1 | Explicitly unprivileged load/store |
| strict_i | input | 1 | Count user-executable pages as user-reachable |
| valid_o | output | 1 | Verdict valid |
| allow_o | output | 1 | Access allowed |
| fault_o | output | 2 | Fault code |

## Verification
The assertions assume that every input is stable and known at the clock edge where `valid_i` is sampled. They also assume that `acc_i` carries one of the three defined access types. The stimulus changes inputs only on the falling edge and draws `acc_i` from read, write and fetch alone. Every other field ranges freely, including level 3 and both settings of `hostx_i`, `unpriv_i` and `strict_i`. Directed cases cover the execute-only page under both strict settings and the case where a guard fault coincides with a write fault.

// File: rtl/perm_chk_pkg.sv
package perm_chk_pkg;
  localparam int AP_W  = 2;
  localparam int EL_W  = 2;
  localparam int ACC_W = 2;
  localparam int FLT_W = 2;

  typedef enum logic [ACC_W-1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_FE  = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  typedef enum logic [FLT_W-1:0] {
    FLT_NONE  = 2'b00,
    FLT_RW    = 2'b01,
    FLT_EXEC  = 2'b10,
    FLT_GUARD = 2'b11
  } flt_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } rwx_t;

  localparam logic [EL_W-1:0] EL_USER = 2'd0;
  localparam logic [EL_W-1:0] EL_KERN = 2'd1;
  localparam logic [EL_W-1:0] EL_HYP  = 2'd2;
endpackage

// File: rtl/perm_decode.sv
module perm_decode
  import perm_chk_pkg::*;
(
  input  logic [AP_W-1:0] ap_i,
  input  logic            uxn_i,
  input  logic            pxn_i,
  output rwx_t            usr_o,
  output rwx_t            krn_o
);
  logic ro, usr_en, usr_wr;

  assign ro     = ap_i[1];
  assign usr_en = ap_i[0];
  assign usr_wr = usr_en & ~ro;

  always_comb begin
    usr_o.r = usr_en;
    usr_o.w = usr_wr;
    usr_o.x = ~uxn_i;
    krn_o.r = 1'b1;
    krn_o.w = ~ro;
    // kernel never executes from a page user level can write
    krn_o.x = ~pxn_i & ~usr_wr;
  end
endmodule

// File: rtl/guard_eval.sv
module guard_eval
  import perm_chk_pkg::*;
(
  input  logic [EL_W-1:0] el_i,
  input  logic            guard_i,
  input  logic            hostx_i,
  input  logic            is_data_i,
  input  logic            unpriv_i,
  input  logic            usr_r_i,
  input  logic            usr_x_i,
  input  logic            strict_i,
  output logic            hit_o
);
  logic lvl_ok, reach;

  assign lvl_ok = (el_i == EL_KERN) | ((el_i == EL_HYP) & hostx_i);
  assign reach  = usr_r_i | (strict_i & usr_x_i);
  assign hit_o  = guard_i & lvl_ok & is_data_i & ~unpriv_i & reach;
endmodule

// File: rtl/fault_sel.sv
module fault_sel
  import perm_chk_pkg::*;
(
  input  acc_e acc_i,
  input  logic use_usr_i,
  input  rwx_t usr_i,
  input  rwx_t krn_i,
  input  logic guard_hit_i,
  output flt_e flt_o
);
  rwx_t ctx;

  assign ctx = use_usr_i ? usr_i : krn_i;

  always_comb begin
    flt_o = FLT_NONE;
    if (guard_hit_i) begin
      flt_o = FLT_GUARD;
    end else begin
      unique case (acc_i)
        ACC_FE:  if (!ctx.x) flt_o = FLT_EXEC;
        ACC_WR:  if (!ctx.w) flt_o = FLT_RW;
        default: if (!ctx.r) flt_o = FLT_RW;
      endcase
    end
  end
endmodule

// File: rtl/perm_check_unit.sv
module perm_check_unit
  import perm_chk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [1:0] ap_i,
  input  logic       uxn_i,
  input  logic       pxn_i,
  input  logic [1:0] el_i,
  input  logic       guard_i,
  input  logic       hostx_i,
  input  logic [1:0] acc_i,
  input  logic       unpriv_i,
  input  logic       strict_i,
  output logic       valid_o,
  output logic       allow_o,
  output logic [1:0] fault_o
);
  rwx_t usr, krn;
  acc_e acc;
  logic is_data, use_usr, guard_hit;
  flt_e flt_d;

  assign acc     = acc_e'(acc_i);
  assign is_data = (acc != ACC_FE);
  // unprivileged marker only retargets loads/stores
  assign use_usr = (el_i == EL_USER) | (unpriv_i & is_data);

  perm_decode u_decode (
    .ap_i  (ap_i),
    .uxn_i (uxn_i),
    .pxn_i (pxn_i),
    .usr_o (usr),
    .krn_o (krn)
  );

  guard_eval u_guard (
    .el_i      (el_i),
    .guard_i   (guard_i),
    .hostx_i   (hostx_i),
    .is_data_i (is_data),
    .unpriv_i  (unpriv_i),
    .usr_r_i   (usr.r),
    .usr_x_i   (usr.x),
    .strict_i  (strict_i),
    .hit_o     (guard_hit)
  );

  fault_sel u_sel (
    .acc_i       (acc),
    .use_usr_i   (use_usr),
    .usr_i       (usr),
    .krn_i       (krn),
    .guard_hit_i (guard_hit),
    .flt_o       (flt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      allow_o <= 1'b0;
      fault_o <= FLT_NONE;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        fault_o <= flt_d;
        allow_o <= (flt_d == FLT_NONE);
      end
    end
  end
endmodule

// File: rtl/perm_check_sva.sv
module perm_check_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [1:0] ap_i,
  input logic       uxn_i,
  input logic       pxn_i,
  input logic [1:0] el_i,
  input logic       guard_i,
  input logic       hostx_i,
  input logic [1:0] acc_i,
  input logic       unpriv_i,
  input logic       strict_i,
  input logic       valid_o,
  input logic       allow_o,
  input logic [1:0] fault_o
);
  a_r12_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r12_valid_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r12_allow_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (allow_o == (fault_o == 2'b00)));
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(fault_o) && $stable(allow_o)));
  a_r9_no_guard_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && acc_i == 2'b10) |=> (fault_o != 2'b11));
  a_r5_guard_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !guard_i) |=> (fault_o != 2'b11));
  a_r6_user_no_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (el_i == 2'd0 || el_i == 2'd3)) |=> (fault_o != 2'b11));
  a_r4_user_fetch_xn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && el_i == 2'd0 && acc_i == 2'b10 && uxn_i) |=> (fault_o == 2'b10));
  a_r3_kern_fetch_pxn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && el_i == 2'd1 && acc_i == 2'b10 && pxn_i) |=> (fault_o == 2'b10));
  a_r10_unpriv_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && unpriv_i && acc_i != 2'b10) |=> (fault_o != 2'b11));
endmodule

bind perm_check_unit perm_check_sva u_sva (.*);

// File: tb/perm_check_unit_tb.sv
`timescale 1ns/1ps
module perm_check_unit_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [1:0] ap_i = '0;
  logic uxn_i = 1'b0, pxn_i = 1'b0;
  logic [1:0] el_i = '0;
  logic guard_i = 1'b0, hostx_i = 1'b0;
  logic [1:0] acc_i = '0;
  logic unpriv_i = 1'b0, strict_i = 1'b0;
  logic valid_o, allow_o;
  logic [1:0] fault_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  perm_check_unit u_dut (.*);

  function automatic logic [1:0] ref_fault(logic [1:0] ap, logic uxn, logic pxn,
      logic [1:0] el, logic g, logic hx, logic [1:0] acc, logic unp, logic st);
    logic data, ur, uw, ux, kw, kx, uctx, plvl, reach, deny;
    data  = (acc != 2'b10);
    ur    = ap[0];
    uw    = (ap == 2'b01);
    ux    = !uxn;
    kw    = !ap[1];
    kx    = !pxn && (ap != 2'b01);
    uctx  = (el == 2'd0) || (data && unp);
    plvl  = (el == 2'd1) || (el == 2'd2 && hx);
    reach = ur || (st && !uxn);
    if (data && !unp && g && plvl && reach) return 2'b11;
    if (!data) deny = uctx ? !ux : !kx;
    else if (acc == 2'b01) deny = uctx ? !uw : !kw;
    else deny = uctx ? !ur : 1'b0;
    if (!data) return deny ? 2'b10 : 2'b00;
    return deny ? 2'b01 : 2'b00;
  endfunction

  task automatic check(string tag, logic [1:0] exp);
    total++;
    if (valid_o !== 1'b1 || fault_o !== exp || allow_o !== (exp == 2'b00)) begin
      bad++;
      $display("FAIL %s: valid=%0b fault=%0b allow=%0b expected valid=1 fault=%0b allow=%0b",
               tag, valid_o, fault_o, allow_o, exp, (exp == 2'b00));
    end
  endtask

  task automatic apply(string tag, logic [1:0] ap, logic uxn, logic pxn, logic [1:0] el,
      logic g, logic hx, logic [1:0] acc, logic unp, logic st, logic [1:0] exp);
    @(negedge clk_i);
    valid_i = 1'b1; ap_i = ap; uxn_i = uxn; pxn_i = pxn; el_i = el;
    guard_i = g; hostx_i = hx; acc_i = acc; unpriv_i = unp; strict_i = st;
    @(negedge clk_i);
    check(tag, exp);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] hf;
    logic ha;
    void'($urandom(32'h5eed_0a11));
    #5;
    total++;
    if (valid_o !== 1'b0 || allow_o !== 1'b0 || fault_o !== 2'b00) begin
      bad++;
      $display("FAIL R13: valid=%0b allow=%0b fault=%0b expected 0 0 00", valid_o, allow_o, fault_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    //     tag     ap    uxn pxn el   g  hx acc  unp st exp
    apply("R1",  2'b10, 1, 0, 2'd1, 0, 0, 2'b01, 0, 0, 2'b01);
    apply("R1",  2'b00, 1, 0, 2'd1, 0, 0, 2'b01, 0, 0, 2'b00);
    apply("R1",  2'b10, 1, 0, 2'd1, 0, 0, 2'b00, 0, 0, 2'b00);
    apply("R2",  2'b10, 1, 0, 2'd0, 0, 0, 2'b00, 0, 0, 2'b01);
    apply("R2",  2'b11, 1, 0, 2'd0, 0, 0, 2'b01, 0, 0, 2'b01);
    apply("R2",  2'b01, 1, 0, 2'd0, 0, 0, 2'b01, 0, 0, 2'b00);
    apply("R2",  2'b10, 0, 0, 2'd0, 0, 0, 2'b10, 0, 0, 2'b00);
    apply("R3",  2'b00, 1, 1, 2'd1, 0, 0, 2'b10, 0, 0, 2'b10);
    apply("R3",  2'b01, 1, 0, 2'd1, 0, 0, 2'b10, 0, 0, 2'b10);
    apply("R3",  2'b11, 1, 0, 2'd1, 0, 0, 2'b10, 0, 0, 2'b00);
    apply("R4",  2'b11, 1, 0, 2'd0, 0, 0, 2'b10, 0, 0, 2'b10);
    apply("R5",  2'b11, 1, 0, 2'd1, 1, 0, 2'b00, 0, 0, 2'b11);
    apply("R5",  2'b11, 1, 0, 2'd1, 0, 0, 2'b00, 0, 0, 2'b00);
    apply("R6",  2'b11, 1, 0, 2'd2, 1, 1, 2'b00, 0, 0, 2'b11);
    apply("R6",  2'b11, 1, 0, 2'd2, 1, 0, 2'b00, 0, 0, 2'b00);
    apply("R6",  2'b11, 1, 0, 2'd3, 1, 1, 2'b00, 0, 0, 2'b00);
    apply("R7",  2'b10, 0, 0, 2'd1, 1, 0, 2'b00, 0, 0, 2'b00);
    apply("R8",  2'b10, 0, 0, 2'd1, 1, 0, 2'b00, 0, 1, 2'b11);
    apply("R8",  2'b10, 1, 0, 2'd1, 1, 0, 2'b00, 0, 1, 2'b00);
    apply("R9",  2'b11, 0, 0, 2'd1, 1, 0, 2'b10, 0, 1, 2'b00);
    apply("R10", 2'b00, 1, 0, 2'd1, 1, 0, 2'b00, 1, 1, 2'b01);
    apply("R10", 2'b11, 1, 0, 2'd1, 1, 0, 2'b00, 1, 1, 2'b00);
    apply("R10", 2'b00, 1, 1, 2'd1, 0, 0, 2'b10, 1, 0, 2'b10);
    apply("R11", 2'b11, 1, 0, 2'd1, 1, 0, 2'b01, 0, 0, 2'b11);

    // R12: no strobe -> valid drops, verdict held
    hf = fault_o;
    ha = allow_o;
    @(negedge clk_i);
    valid_i = 1'b0; ap_i = 2'b00; el_i = 2'd1; acc_i = 2'b00; guard_i = 1'b0;
    @(negedge clk_i);
    total++;
    if (valid_o !== 1'b0 || fault_o !== hf || allow_o !== ha) begin
      bad++;
      $display("FAIL R12: valid=%0b fault=%0b allow=%0b expected valid=0 fault=%0b allow=%0b",
               valid_o, fault_o, allow_o, hf, ha);
    end

    for (int i = 0; i < 4000; i++) begin
      logic [1:0] ap, el, acc;
      logic uxn, pxn, g, hx, unp, st;
      ap  = 2'($urandom_range(0, 3));
      el  = 2'($urandom_range(0, 3));
      acc = 2'($urandom_range(0, 2));
      uxn = 1'($urandom_range(0, 1));
      pxn = 1'($urandom_range(0, 1));
      g   = 1'($urandom_range(0, 1));
      hx  = 1'($urandom_range(0, 1));
      unp = 1'($urandom_range(0, 1));
      st  = 1'($urandom_range(0, 1));
      apply("R12 random", ap, uxn, pxn, el, g, hx, acc, unp, st,
            ref_fault(ap, uxn, pxn, el, g, hx, acc, unp, st));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule